// File: doc/BRIEF.md
# Low-Speed USB Line Condition Monitor

This block watches the received D+ and D− levels of a low-speed USB port and sorts what it sees into three timed conditions. A short single-ended zero that returns to the idle J state marks an end of packet. A single-ended zero that lasts too long is a bus reset. A J state that persists with no packet traffic asks for suspend. All three decisions are timed in microseconds by counting a one-cycle `us_tick` strobe supplied by the surrounding clock logic.

Both line inputs first pass through a two-flop synchronizer. Each timed decision is then made on the synchronized line state. Two counters hold all of the timing. One measures how long the current single-ended zero has lasted. The other measures how long the idle J state has lasted, and any end of packet or any non-idle state clears it, so the host's periodic keep-alive end-of-packet markers hold suspend off. Acting on a suspend request, such as entering a low-power mode, is handled elsewhere.

Top module: `usb_linemon`

## Requirements
- R1: The line state is taken from `{dp_in, dm_in}` after two synchronizing flops: `00` is SE0, `01` is idle J, `10` is K and `11` is SE1. Every output reacts to the synchronized state, never to the raw pins.
- R2: An SE0 that spans fewer than `RST_US` microsecond ticks and is directly followed by J raises `eop_pulse` for exactly one clock cycle.
- R3: An SE0 followed by K or SE1 instead of J produces no `eop_pulse`.
- R4: Once an SE0 has spanned `RST_US` ticks, `bus_reset` goes high and stays high for as long as SE0 remains. It goes low once SE0 ends.
- R5: An SE0 that reached reset length produces no `eop_pulse` when it ends. Instead, `reset_done` pulses high for one cycle directly after `bus_reset` falls.
- R6: `suspend_req` rises after the synchronized line has stayed in J for `SUSP_US` ticks, and not before.
- R7: Every end of packet and every non-J state restarts the idle count, so keep-alive markers sent more often than `SUSP_US` ticks apart hold `suspend_req` low.
- R8: `suspend_req` falls in the cycle after a non-J synchronized state appears.
- R9: While `rst_n` is low, and directly after it is released with the line idle, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| dp_in | input | 1 | Received D+ level |
| dm_in | input | 1 | Received D− level |
| eop_pulse | output | 1 | One-cycle end-of-packet event |
| bus_reset | output | 1 | High while a reset-length SE0 is on the bus |
| reset_done | output | 1 | One-cycle pulse after a bus reset ends |
| suspend_req | output | 1 | High while the bus has idled past the suspend limit |

## Verification
The bench sweeps the SE0 length in whole microsecond ticks across both sides of the reset threshold and ends each SE0 in J. For every length it counts end-of-packet pulses, reset-high cycles and reset-done pulses, which separates the end-of-packet case from the reset case exactly at the threshold. Short SE0s that end in K or SE1 show that only a return to J counts as an end of packet. Idle stretches just short of and just past the suspend limit locate the suspend edge. Repeated keep-alive markers, and separately a lone K, show that the idle count restarts. A K after suspend shows that suspend is released.

// File: rtl/lmon_pkg.sv
package lmon_pkg;
  // encoding is {dp, dm} after synchronization
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;
endpackage

// File: rtl/lmon_sync.sv
module lmon_sync
  import lmon_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dp_in,
  input  logic  dm_in,
  output line_t line_st
);
  logic [STAGES-1:0] dp_q, dm_q;
  logic [STAGES-1:0] dp_d, dm_d;

  always_comb begin
    dp_d = {dp_q[STAGES-2:0], dp_in};
    dm_d = {dm_q[STAGES-2:0], dm_in};
  end

  // reset to idle J so no event is seen at reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q <= '0;
      dm_q <= '1;
    end else begin
      dp_q <= dp_d;
      dm_q <= dm_d;
    end
  end

  assign line_st = line_t'({dp_q[STAGES-1], dm_q[STAGES-1]});
endmodule

// File: rtl/lmon_se0_timer.sv
module lmon_se0_timer
  import lmon_pkg::*;
#(
  parameter int RST_US = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  us_tick,
  input  line_t line_st,
  output logic  eop_pulse,
  output logic  bus_reset,
  output logic  reset_done
);
  localparam int W = $clog2(RST_US + 1);
  localparam logic [W-1:0] LIM = W'(RST_US);

  logic [W-1:0] cnt_q, cnt_d;
  logic         prev_se0_q;
  logic         rst_q, rst_d;
  logic         eop_q, eop_d;
  logic         done_q, done_d;
  logic         is_se0;

  always_comb begin
    is_se0 = (line_st == LS_SE0);
    if (!is_se0)
      cnt_d = '0;
    else if (us_tick && (cnt_q != LIM))
      cnt_d = cnt_q + W'(1);
    else
      cnt_d = cnt_q;
    rst_d  = is_se0 && (cnt_d == LIM);
    eop_d  = prev_se0_q && (line_st == LS_J) && (cnt_q != LIM);
    done_d = rst_q && !is_se0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      prev_se0_q <= 1'b0;
      rst_q      <= 1'b0;
      eop_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      prev_se0_q <= is_se0;
      rst_q      <= rst_d;
      eop_q      <= eop_d;
      done_q     <= done_d;
    end
  end

  assign eop_pulse  = eop_q;
  assign bus_reset  = rst_q;
  assign reset_done = done_q;
endmodule

// File: rtl/lmon_idle_timer.sv
module lmon_idle_timer
  import lmon_pkg::*;
#(
  parameter int SUSP_US = 3000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  us_tick,
  input  line_t line_st,
  input  logic  eop_seen,
  output logic  suspend_req
);
  localparam int W = $clog2(SUSP_US + 1);
  localparam logic [W-1:0] LIM = W'(SUSP_US);

  logic [W-1:0] cnt_q, cnt_d;
  logic         susp_q, susp_d;
  logic         is_j;

  always_comb begin
    is_j = (line_st == LS_J);
    if (!is_j || eop_seen)
      cnt_d = '0;
    else if (us_tick && (cnt_q != LIM))
      cnt_d = cnt_q + W'(1);
    else
      cnt_d = cnt_q;
    susp_d = is_j && (cnt_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      susp_q <= susp_d;
    end
  end

  assign suspend_req = susp_q;
endmodule

// File: rtl/usb_linemon.sv
module usb_linemon
  import lmon_pkg::*;
#(
  parameter int RST_US  = 4,
  parameter int SUSP_US = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic dp_in,
  input  logic dm_in,
  output logic eop_pulse,
  output logic bus_reset,
  output logic reset_done,
  output logic suspend_req
);
  line_t line_st;
  logic  eop_w;

  lmon_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .dp_in   (dp_in),
    .dm_in   (dm_in),
    .line_st (line_st)
  );

  lmon_se0_timer #(.RST_US(RST_US)) u_se0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .line_st    (line_st),
    .eop_pulse  (eop_w),
    .bus_reset  (bus_reset),
    .reset_done (reset_done)
  );

  lmon_idle_timer #(.SUSP_US(SUSP_US)) u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .us_tick     (us_tick),
    .line_st     (line_st),
    .eop_seen    (eop_w),
    .suspend_req (suspend_req)
  );

  assign eop_pulse = eop_w;
endmodule

// File: rtl/lmon_chk.sv
module lmon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_st,
  input logic       eop_pulse,
  input logic       bus_reset,
  input logic       reset_done,
  input logic       suspend_req
);
  p_eop_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pulse |=> !eop_pulse);

  p_eop_after_j_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pulse |-> $past(line_st) == 2'b01);

  p_reset_from_se0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_reset) |-> $past(line_st) == 2'b00);

  p_reset_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && line_st == 2'b00) |=> bus_reset);

  p_no_eop_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pulse |-> !bus_reset);

  p_done_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |-> $past(bus_reset) && !bus_reset);

  p_susp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_st != 2'b01) |=> !suspend_req);
endmodule

bind usb_linemon lmon_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_st     (line_st),
  .eop_pulse   (eop_pulse),
  .bus_reset   (bus_reset),
  .reset_done  (reset_done),
  .suspend_req (suspend_req)
);

// File: tb/sim_usb_linemon.sv
`timescale 1ns/1ps
module sim_usb_linemon;
  localparam int RST_US  = 4;
  localparam int SUSP_US = 20;
  localparam int TICK_DIV = 4;

  logic clk, rst_n, us_tick, dp, dm;
  logic eop_pulse, bus_reset, reset_done, suspend_req;
  int   tcnt;
  int   nchk, nfail;
  int   c_eop, c_rst, c_done, c_susp;
  bit   finished;

  usb_linemon #(.RST_US(RST_US), .SUSP_US(SUSP_US)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .dp_in(dp), .dm_in(dm),
    .eop_pulse(eop_pulse), .bus_reset(bus_reset),
    .reset_done(reset_done), .suspend_req(suspend_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // one tick in every TICK_DIV cycles: any TICK_DIV*n window holds n ticks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= 0;
    else        tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
  end
  assign us_tick = (tcnt == TICK_DIV - 1);

  always @(negedge clk) begin
    if (rst_n) begin
      c_eop  <= c_eop  + int'(eop_pulse);
      c_rst  <= c_rst  + int'(bus_reset);
      c_done <= c_done + int'(reset_done);
      c_susp <= c_susp + int'(suspend_req);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at posedge+1; returns at posedge+1 after n cycles
  task automatic hold(input logic p, input logic m, input int n);
    dp = p; dm = m;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr();
    c_eop = 0; c_rst = 0; c_done = 0; c_susp = 0;
  endtask

  initial begin
    nchk = 0; nfail = 0; finished = 0;
    clr();
    rst_n = 1'b0; dp = 1'b0; dm = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 eop in reset", int'(eop_pulse), 0);
    chk("R9 reset in reset", int'(bus_reset), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 eop after release", int'(eop_pulse), 0);
    chk("R9 bus_reset after release", int'(bus_reset), 0);
    chk("R9 reset_done after release", int'(reset_done), 0);
    chk("R9 suspend after release", int'(suspend_req), 0);

    // SE0 length sweep in ticks, each ending in J
    for (int d = 1; d <= 8; d++) begin
      hold(1'b0, 1'b1, 20);
      clr();
      hold(1'b0, 1'b0, d * TICK_DIV);
      if (d >= RST_US + 1)
        chk("R4 bus_reset held during SE0", int'(bus_reset), 1);
      hold(1'b0, 1'b1, 12);
      chk("R2/R5 eop count", c_eop, (d < RST_US) ? 1 : 0);
      chk("R4 reset seen", int'(c_rst > 0), (d >= RST_US) ? 1 : 0);
      chk("R5 reset_done count", c_done, (d >= RST_US) ? 1 : 0);
      chk("R4 bus_reset low after SE0", int'(bus_reset), 0);
    end

    // R1: a one-cycle SE0 glitch at the pins still shows up through the synchronizer
    hold(1'b0, 1'b1, 20);
    clr();
    hold(1'b0, 1'b0, 1);
    hold(1'b0, 1'b1, 8);
    chk("R1 synchronized SE0 then J gives eop", c_eop, 1);

    // R3: short SE0 ending in K or SE1
    for (int e = 0; e < 2; e++) begin
      hold(1'b0, 1'b1, 20);
      clr();
      hold(1'b0, 1'b0, 2 * TICK_DIV);
      hold(1'b1, (e == 1) ? 1'b1 : 1'b0, 8);
      hold(1'b0, 1'b1, 8);
      chk("R3 no eop after non-J end", c_eop, 0);
    end

    // R6: suspend edge
    hold(1'b1, 1'b0, 8);
    hold(1'b0, 1'b1, (SUSP_US - 1) * TICK_DIV);
    chk("R6 no suspend before limit", int'(suspend_req), 0);
    hold(1'b0, 1'b1, 12);
    chk("R6 suspend after limit", int'(suspend_req), 1);
    // R8: K clears it
    hold(1'b1, 1'b0, 4);
    chk("R8 suspend cleared by K", int'(suspend_req), 0);

    // R7: keep-alive EOPs hold suspend off
    hold(1'b0, 1'b1, 8);
    clr();
    for (int i = 0; i < 6; i++) begin
      hold(1'b0, 1'b1, (SUSP_US - 5) * TICK_DIV);
      hold(1'b0, 1'b0, 2 * TICK_DIV);
    end
    hold(1'b0, 1'b1, 12);
    chk("R7 keep-alive eops seen", c_eop, 6);
    chk("R7 no suspend under keep-alive", c_susp, 0);

    // R7: a lone K also restarts the idle count
    clr();
    hold(1'b0, 1'b1, (SUSP_US - 5) * TICK_DIV);
    hold(1'b1, 1'b0, 8);
    hold(1'b0, 1'b1, (SUSP_US - 5) * TICK_DIV);
    chk("R7 K restarts idle count", c_susp, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule